// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block multiplies two signed 16-bit Q15 operands and writes the 32-bit product into a 40-bit accumulator, or adds it there. The upper eight bits are guard bits, so a running sum may grow past the 32-bit range and shrink again without being clipped. Each cycle with a valid input carries one operation: do nothing, clear the accumulator, load it from an operand, replace it with the product, or add the product to it. The new accumulator value appears one clock edge after the operation is presented.

A mode input picks how the product is aligned. In integer alignment the Q30 product is used as it is. In fractional alignment the product is doubled to Q31. The one product whose doubling cannot be represented (-1 times -1) is clamped to the largest positive 32-bit value. A combinational readout turns the accumulator back into a Q15 word, with optional round-half-up and optional clamping. Two flags report trouble: one for a Q15 result outside the 16-bit range, and one for a wrap of the 40-bit accumulator itself.

Top module: `fmac_core`

## Requirements
- R1: After reset the accumulator is zero, the Q15 readout is 0x0000, and both flags are low.
- R2: With `frac_mode` low, MPY sets the accumulator to the sign-extended 32-bit two's-complement product (Q30). For example, 0x4000 x 0x2000 gives 0x0008000000 and 0xFF00 x 0xFE00 gives 0x0000020000.
- R3: With `frac_mode` high, MPY sets the accumulator to the product shifted left by one bit (Q31), sign-extended. For example, 0x0055 x 0xDA51 gives 0xFFFFE6F9CA.
- R4: With `frac_mode` high, the operands 0x8000 x 0x8000 give 0x007FFFFFFF, not a negative value.
- R5: MAC adds the aligned product (as in R2/R3) to the accumulator modulo 2^40, with no saturation. Sums beyond the 32-bit range are kept exactly.
- R6: `acc_wrap` goes high on the edge where a MAC sum leaves the signed 40-bit range. It stays high until a CLR, LOAD or MPY is accepted.
- R7: CLR (op 1) sets the accumulator to zero and clears both sticky flags. LOAD (op 2) sets it to `in_a` sign-extended and shifted left by 15 bits (integer mode) or 16 bits (fractional mode).
- R8: With `in_valid` low, or with op code NOP (0) or an unused code (5 to 7), the accumulator and `acc_wrap` do not change. Op codes are MPY = 3 and MAC = 4.
- R9: The readout is the accumulator arithmetically shifted right by 15 bits (integer mode) or 16 bits (fractional mode). When `round_en` is high, 2^14 or 2^15 is added first.
- R10: When the R9 value lies outside -32768..32767 and `sat_en` is high, the readout is 0x7FFF (positive) or 0x8000 (negative). With `sat_en` low it is the low 16 bits of that value.
- R11: `q15_ovf` is high while the R9 value is out of range. It stays high afterwards until a CLR is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 16 | Q15 operand A (also the load value) |
| in_b | input | 16 | Q15 operand B |
| frac_mode | input | 1 | 1: product doubled to Q31; 0: Q30 kept |
| round_en | input | 1 | Round half up in the Q15 readout |
| sat_en | input | 1 | Clamp the Q15 readout when out of range |
| acc_out | output | 40 | Accumulator |
| q15_out | output | 16 | Q15 readout of the accumulator |
| q15_ovf | output | 1 | Readout out of range, sticky until CLR |
| acc_wrap | output | 1 | Accumulator wrapped, sticky until overwrite |

## Verification
Directed products cover the two alignments:
- Small positive, mixed-sign and two-negative operand pairs show whether the sign extension and the one-bit doubling are right.
- The 0x8000 x 0x8000 pair, run in both modes, separates the clamped fractional case from the unclamped integer case, whose readout must then saturate.

A run of 257 additions of the largest fractional product confirms that the sum keeps growing past 32 bits and that the wrap flag rises exactly on the 257th addition. Random operations with frequent extreme operands, and random mode, rounding and clamping settings, check every accumulator value and readout against a 64-bit bench model.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_MPY  = 3'd3,
    OP_MAC  = 3'd4
  } fmac_op_e;
endpackage

// File: rtl/fmac_product.sv
module fmac_product #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             frac,
  output logic [2*OPW-1:0] prod
);
  localparam int PW = 2 * OPW;

  logic signed [PW-1:0] ax, bx, raw;
  logic                 neg_one_sq;

  // full-width signed product: Q30 for Q15 operands, two sign bits
  function automatic logic [PW-1:0] align(input logic [PW-1:0] p, input logic f,
                                          input logic clamp);
    if (clamp) return {1'b0, {(PW-1){1'b1}}};
    if (f)     return {p[PW-2:0], 1'b0};
    return p;
  endfunction

  assign ax         = {{OPW{a[OPW-1]}}, a};
  assign bx         = {{OPW{b[OPW-1]}}, b};
  assign raw        = ax * bx;
  assign neg_one_sq = frac && (raw == {2'b01, {(PW-2){1'b0}}});
  assign prod       = align(raw, frac, neg_one_sq);
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
  import fmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [2:0]      op,
  input  logic            frac,
  input  logic [OPW-1:0]  load_a,
  input  logic [2*OPW-1:0] prod,
  output logic [ACCW-1:0] acc,
  output logic            wrap_sticky
);
  localparam int PW  = 2 * OPW;
  localparam int GW  = ACCW - PW;

  logic [ACCW-1:0] prod_ext, sum, load_val;
  logic            wrap_evt;

  assign prod_ext = {{GW{prod[PW-1]}}, prod};
  assign sum      = acc + prod_ext;
  // same-sign addends giving a result of the other sign: 40-bit wrap
  assign wrap_evt = (acc[ACCW-1] == prod_ext[ACCW-1]) && (sum[ACCW-1] != acc[ACCW-1]);
  assign load_val = frac ? {{GW{load_a[OPW-1]}}, load_a, {OPW{1'b0}}}
                         : {{(GW+1){load_a[OPW-1]}}, load_a, {(OPW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      wrap_sticky <= 1'b0;
    end else if (valid) begin
      case (op)
        OP_CLR:  begin acc <= '0;       wrap_sticky <= 1'b0; end
        OP_LOAD: begin acc <= load_val; wrap_sticky <= 1'b0; end
        OP_MPY:  begin acc <= prod_ext; wrap_sticky <= 1'b0; end
        OP_MAC:  begin acc <= sum;      wrap_sticky <= wrap_sticky | wrap_evt; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fmac_readout.sv
module fmac_readout #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic [ACCW-1:0] acc,
  input  logic            frac,
  input  logic            round_en,
  input  logic            sat_en,
  output logic [OPW-1:0]  q,
  output logic            oor
);
  logic signed [ACCW:0] acc_x, rnd, sum, shifted;
  logic [ACCW-OPW+1:0]  hi;

  function automatic logic [ACCW:0] half_lsb(input logic f);
    logic [ACCW:0] one;
    one = {{ACCW{1'b0}}, 1'b1};
    return f ? (one << (OPW-1)) : (one << (OPW-2));
  endfunction

  function automatic logic [OPW-1:0] clamp(input logic neg);
    return neg ? {1'b1, {(OPW-1){1'b0}}} : {1'b0, {(OPW-1){1'b1}}};
  endfunction

  assign acc_x   = {acc[ACCW-1], acc};
  assign rnd     = round_en ? half_lsb(frac) : '0;
  assign sum     = acc_x + rnd;
  assign shifted = frac ? (sum >>> OPW) : (sum >>> (OPW-1));
  assign hi      = shifted[ACCW:OPW-1];
  assign oor     = !((&hi) || !(|hi));
  assign q       = (oor && sat_en) ? clamp(shifted[ACCW]) : shifted[OPW-1:0];
endmodule

// File: rtl/fmac_core.sv
module fmac_core
  import fmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      in_op,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  input  logic            frac_mode,
  input  logic            round_en,
  input  logic            sat_en,
  output logic [ACCW-1:0] acc_out,
  output logic [OPW-1:0]  q15_out,
  output logic            q15_ovf,
  output logic            acc_wrap
);
  logic [2*OPW-1:0] prod_w;
  logic             readout_oor;
  logic             ovf_q;

  fmac_product #(.OPW(OPW)) u_prod (
    .a(in_a), .b(in_b), .frac(frac_mode), .prod(prod_w)
  );

  fmac_accum #(.OPW(OPW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .op(in_op), .frac(frac_mode),
    .load_a(in_a), .prod(prod_w), .acc(acc_out), .wrap_sticky(acc_wrap)
  );

  fmac_readout #(.OPW(OPW), .ACCW(ACCW)) u_rd (
    .acc(acc_out), .frac(frac_mode), .round_en(round_en), .sat_en(sat_en),
    .q(q15_out), .oor(readout_oor)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ovf_q <= 1'b0;
    else if (in_valid && in_op == OP_CLR)   ovf_q <= 1'b0;
    else if (readout_oor)                   ovf_q <= 1'b1;
  end

  assign q15_ovf = ovf_q | readout_oor;
endmodule

// File: rtl/fmac_checker.sv
module fmac_checker
  import fmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      in_op,
  input logic [OPW-1:0]  in_a,
  input logic [OPW-1:0]  in_b,
  input logic            frac_mode,
  input logic            sat_en,
  input logic [ACCW-1:0] acc_out,
  input logic [OPW-1:0]  q15_out,
  input logic            q15_ovf,
  input logic            acc_wrap,
  input logic            readout_oor
);
  localparam logic [ACCW-1:0] POS_MAX32 = {{(ACCW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};
  localparam logic [OPW-1:0]  MOST_NEG  = {1'b1, {(OPW-1){1'b0}}};

  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_CLR) |=> (acc_out == '0 && !acc_wrap && !q15_ovf));

  assert_neg_one_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_MPY && frac_mode && in_a == MOST_NEG && in_b == MOST_NEG)
      |=> (acc_out == POS_MAX32));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_out) && $stable(acc_wrap)));

  assert_sat_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_oor && sat_en) |-> (q15_out == ~MOST_NEG || q15_out == MOST_NEG));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q15_ovf && !(in_valid && in_op == OP_CLR)) |=> q15_ovf);

  assert_wrap_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_wrap) |-> $past(in_valid && in_op == OP_MAC));

  assert_wrap_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_MPY) |=> !acc_wrap);
endmodule

bind fmac_core fmac_checker #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
  .in_b(in_b), .frac_mode(frac_mode), .sat_en(sat_en), .acc_out(acc_out),
  .q15_out(q15_out), .q15_ovf(q15_ovf), .acc_wrap(acc_wrap),
  .readout_oor(readout_oor)
);

// File: tb/sim_fmac_core.sv
module sim_fmac_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [15:0] in_a, in_b;
  logic        frac_mode, round_en, sat_en;
  logic [39:0] acc_out;
  logic [15:0] q15_out;
  logic        q15_ovf, acc_wrap;

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 0;
  longint m_acc  = 0;
  bit     m_wrap = 0;
  bit     m_ovf  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmac_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .frac_mode(frac_mode), .round_en(round_en), .sat_en(sat_en),
    .acc_out(acc_out), .q15_out(q15_out), .q15_ovf(q15_ovf), .acc_wrap(acc_wrap)
  );

  function automatic longint to40(longint v);
    return (v <<< 24) >>> 24;
  endfunction

  function automatic longint prod_of(logic [15:0] a, logic [15:0] b, bit fm);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    if (fm) p = (p == 64'sh40000000) ? 64'sh7FFFFFFF : p * 2;
    return p;
  endfunction

  function automatic longint q_of(longint acc, bit fm, bit rd);
    longint v;
    int sh;
    sh = fm ? 16 : 15;
    v = acc;
    if (rd) v = v + (longint'(1) <<< (sh - 1));
    return v >>> sh;
  endfunction

  function automatic bit out_of_range(longint q);
    return (q > 32767) || (q < -32768);
  endfunction

  function automatic logic [15:0] q_word(longint q, bit st);
    if (out_of_range(q) && st) return (q > 0) ? 16'h7FFF : 16'h8000;
    return q[15:0];
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [15:0] a, logic [15:0] b,
                      bit fm, bit rd, bit st);
    longint q_pre, p, s, q;
    string  tag;
    in_valid = v; in_op = op; in_a = a; in_b = b;
    frac_mode = fm; round_en = rd; sat_en = st;
    q_pre = q_of(m_acc, fm, rd);
    p = prod_of(a, b, fm);
    tag = "R8";
    @(posedge clk);
    if (v && op == 3'd1) m_ovf = 0;
    else if (out_of_range(q_pre)) m_ovf = 1;
    if (v) begin
      case (op)
        3'd1: begin m_acc = 0; m_wrap = 0; tag = "R7"; end
        3'd2: begin m_acc = longint'($signed(a)) <<< (fm ? 16 : 15); m_wrap = 0; tag = "R7"; end
        3'd3: begin m_acc = p; m_wrap = 0; tag = fm ? "R3" : "R2"; end
        3'd4: begin
          s = m_acc + p;
          if (s != to40(s)) m_wrap = 1;
          m_acc = to40(s);
          tag = "R5";
        end
        default: ;
      endcase
    end
    @(negedge clk);
    q = q_of(m_acc, fm, rd);
    check(tag, "acc", longint'($signed(acc_out)), m_acc);
    check((out_of_range(q) && st) ? "R10" : "R9", "q15", longint'(q15_out),
          longint'(q_word(q, st)));
    check("R11", "q15_ovf", longint'(q15_ovf), longint'(m_ovf | out_of_range(q)));
    check("R6", "acc_wrap", longint'(acc_wrap), longint'(m_wrap));
  endtask

  function automatic logic [15:0] pick_operand();
    case ($urandom_range(0, 9))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; in_op = 0; in_a = 0; in_b = 0;
    frac_mode = 0; round_en = 0; sat_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "acc", longint'(acc_out), 0);
    check("R1", "q15", longint'(q15_out), 0);
    check("R1", "flags", longint'({q15_ovf, acc_wrap}), 0);

    // R2: integer alignment examples
    step(1, 3'd3, 16'h4000, 16'h2000, 0, 0, 1);
    check("R2", "0x4000*0x2000", longint'(acc_out), 64'h0008000000);
    check("R9", "q15 of 0.125", longint'(q15_out), 64'h1000);
    step(1, 3'd3, 16'hFF00, 16'hFE00, 0, 0, 1);
    check("R2", "0xFF00*0xFE00", longint'(acc_out), 64'h0000020000);
    // R3: fractional alignment example
    step(1, 3'd3, 16'h0055, 16'hDA51, 1, 0, 1);
    check("R3", "0x0055*0xDA51", longint'(acc_out), 64'hFFFFE6F9CA);
    // R4: -1 x -1 in both modes
    step(1, 3'd3, 16'h8000, 16'h8000, 1, 0, 1);
    check("R4", "frac -1*-1", longint'(acc_out), 64'h007FFFFFFF);
    check("R9", "frac readout", longint'(q15_out), 64'h7FFF);
    step(1, 3'd3, 16'h8000, 16'h8000, 0, 0, 1);
    check("R10", "int -1*-1 clamped", longint'(q15_out), 64'h7FFF);
    check("R11", "ovf set", longint'(q15_ovf), 1);
    step(0, 3'd0, 16'h0, 16'h0, 0, 0, 0);
    check("R10", "unclamped", longint'(q15_out), 64'h8000);
    step(1, 3'd2, 16'h0000, 16'h0, 0, 0, 1);
    check("R11", "ovf held after load", longint'(q15_ovf), 1);
    step(1, 3'd1, 16'h0, 16'h0, 0, 0, 1);
    check("R7", "clr clears ovf", longint'(q15_ovf), 0);
    // R7: load readout returns the operand
    step(1, 3'd2, 16'h1234, 16'h0, 0, 0, 1);
    check("R7", "load int", longint'(q15_out), 64'h1234);
    step(1, 3'd2, 16'hC001, 16'h0, 1, 0, 1);
    check("R7", "load frac", longint'(acc_out), 64'hFFC0010000);
    // R9: rounding
    step(1, 3'd3, 16'h0001, 16'h4000, 0, 0, 1);
    check("R9", "truncate", longint'(q15_out), 0);
    step(1, 3'd0, 16'h0, 16'h0, 0, 1, 1);
    check("R9", "round up", longint'(q15_out), 1);
    // R8: ignored codes
    step(1, 3'd7, 16'h7FFF, 16'h7FFF, 0, 0, 1);
    step(1, 3'd5, 16'h7FFF, 16'h7FFF, 0, 0, 1);
    check("R8", "unused code", longint'(acc_out), 64'h4000);

    // R5/R6: growth past 32 bits, then wrap on the 257th addition
    step(1, 3'd1, 16'h0, 16'h0, 1, 0, 1);
    for (int i = 0; i < 257; i++) begin
      step(1, 3'd4, 16'h8000, 16'h8000, 1, 0, 1);
      if (i == 1) check("R5", "two sums", longint'(acc_out), 64'h00FFFFFFFE);
      if (i == 255) check("R6", "no wrap yet", longint'(acc_wrap), 0);
    end
    check("R6", "wrap raised", longint'(acc_wrap), 1);
    step(0, 3'd4, 16'h0, 16'h0, 1, 0, 1);
    check("R8", "wrap kept while idle", longint'(acc_wrap), 1);
    step(1, 3'd3, 16'h0, 16'h0, 1, 0, 1);
    check("R6", "wrap cleared by MPY", longint'(acc_wrap), 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      case ($urandom_range(0, 9))
        0: op = 3'd0;
        1: op = 3'd1;
        2: op = 3'd2;
        3, 4: op = 3'd3;
        9: op = 3'd6;
        default: op = 3'd4;
      endcase
      step($urandom_range(0, 7) != 0, op, pick_operand(), pick_operand(),
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule